// File: doc/BRIEF.md
# Pattern RAM Command Front End

This block sits between a register bus and a waveform sequencer's 64-entry by 32-bit pattern RAM. Software reaches the RAM only through three registers. A data register holds a word. An address register holds the external bus address used during software-started runs. A mode register holds a 2-bit opcode and a 6-bit RAM index.

Writing the mode register only arms a command. The command fires on the next access that hits the memory bank the sequencer serves. Depending on the armed opcode, that bank hit does one of four things: it passes to the sequencer as an ordinary access, it stores the data register into the RAM, it loads a RAM word into the data register, or it starts the sequencer at the programmed index.

The opcode is not cleared after it fires. To load a whole table, software writes the data register, then writes the mode register with the write opcode and the next index, then touches the bank. It repeats these three steps for each word.

Top module: `pram_cmd_if`

## Requirements
- R1: After reset, the data, address and mode registers read zero, and every strobe output (`ram_we_o`, `ram_re_o`, `run_req_o`, `mem_access_o`, `bank_ack_o`) is low.
- R2: Register offsets are data=0, address=1, mode=2. The mode register keeps the opcode in bits [9:8] and the index in bits [5:0], and its other bits read as zero. Offset 3 reads zero. Each writable register reads back what was last written.
- R3: With opcode 00 (normal), a bank hit raises `mem_access_o` for one cycle, starting the cycle after the hit. It raises no RAM strobe, no run request and no acknowledge.
- R4: With opcode 01 (write), a bank hit raises `ram_we_o` for one cycle, starting the cycle after the hit. During that cycle `ram_idx_o` equals the mode index, `ram_wdata_o` equals the data register, and `bank_ack_o` is high.
- R5: With opcode 10 (read), a bank hit raises `ram_re_o` with `ram_idx_o` equal to the mode index, in the cycle after the hit. In the following cycle `bank_ack_o` is high and the data register holds the RAM word, so the acknowledge comes two cycles after the hit.
- R6: With opcode 11 (run), a bank hit raises `run_req_o` for one cycle, starting the cycle after the hit. During that cycle `run_idx_o` equals the mode index and `run_addr_o` equals the address register. No acknowledge and no RAM strobe is raised.
- R7: The armed opcode stays in place after it fires. Every further bank hit under opcode 01 performs another RAM write, and the mode register reads back unchanged.
- R8: Writing the mode register alone, with no bank hit, performs no RAM access and no run.
- R9: A bank hit that arrives in the cycle while a RAM read is pending is ignored, so back-to-back hits under opcode 10 give exactly one read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` (combinational) |
| bank_hit_i | input | 1 | One-cycle pulse: a bus access hit the bank |
| bank_ack_o | output | 1 | Completion of a RAM write or read access |
| mem_access_o | output | 1 | Normal access forwarded to the sequencer |
| ram_we_o | output | 1 | Pattern RAM write strobe |
| ram_re_o | output | 1 | Pattern RAM read strobe |
| ram_idx_o | output | 6 | Pattern RAM index |
| ram_wdata_o | output | 32 | Pattern RAM write data |
| ram_rdata_i | input | 32 | Pattern RAM read data, valid in the cycle `ram_re_o` is high |
| run_req_o | output | 1 | Sequencer start request |
| run_idx_o | output | 6 | Sequencer start index |
| run_addr_o | output | 32 | External address for a software-started run |

## Verification
The assertions assume the following about the inputs:
- `bank_hit_i` is a single-cycle pulse per access.
- The RAM returns the word for `ram_idx_o` in the cycle `ram_re_o` is high.
- Software does not write the data register in the cycle a RAM read result is loaded.

The stimulus keeps within these limits. Each hit is driven for exactly one cycle, the bench's RAM model answers combinationally, and register writes happen only after the acknowledge has been seen. The one deliberate exception is a pair of back-to-back hits under the read opcode, used to show that the second one is dropped.

// File: rtl/pram_cmd_pkg.sv
package pram_cmd_pkg;
  typedef enum logic [1:0] {
    OP_NORM  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_RUN   = 2'b11
  } pram_op_e;

  localparam int REG_AW = 2;
  localparam logic [REG_AW-1:0] OFS_DATA = 2'd0;
  localparam logic [REG_AW-1:0] OFS_ADDR = 2'd1;
  localparam logic [REG_AW-1:0] OFS_MODE = 2'd2;
  localparam int MODE_OP_LSB = 8;
endpackage

// File: rtl/pram_cmd_regs.sv
module pram_cmd_regs
  import pram_cmd_pkg::*;
#(
  parameter int DW = 32,
  parameter int IW = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              load_i,
  input  logic [DW-1:0]     load_data_i,
  output logic [DW-1:0]     rdata_o,
  output logic [DW-1:0]     data_o,
  output logic [DW-1:0]     xaddr_o,
  output pram_op_e          op_o,
  output logic [IW-1:0]     idx_o
);
  logic [DW-1:0] data_q, xaddr_q;
  pram_op_e      op_q;
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      xaddr_q <= '0;
      op_q    <= OP_NORM;
      idx_q   <= '0;
    end else begin
      // a read result takes priority over a bus write to the data register
      if (load_i) data_q <= load_data_i;
      else if (wr_i && addr_i == OFS_DATA) data_q <= wdata_i;
      if (wr_i && addr_i == OFS_ADDR) xaddr_q <= wdata_i;
      if (wr_i && addr_i == OFS_MODE) begin
        op_q  <= pram_op_e'(wdata_i[MODE_OP_LSB +: 2]);
        idx_q <= wdata_i[IW-1:0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_DATA: rdata_o = data_q;
      OFS_ADDR: rdata_o = xaddr_q;
      OFS_MODE: begin
        rdata_o[MODE_OP_LSB +: 2] = op_q;
        rdata_o[IW-1:0]           = idx_q;
      end
      default:  rdata_o = '0;
    endcase
  end

  assign data_o  = data_q;
  assign xaddr_o = xaddr_q;
  assign op_o    = op_q;
  assign idx_o   = idx_q;

  // R5
  load_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> data_q == $past(load_data_i));
endmodule

// File: rtl/pram_cmd_exec.sv
module pram_cmd_exec
  import pram_cmd_pkg::*;
#(
  parameter int IW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hit_i,
  input  pram_op_e      op_i,
  input  logic [IW-1:0] idx_i,
  output logic          ram_we_o,
  output logic          ram_re_o,
  output logic [IW-1:0] ram_idx_o,
  output logic          run_req_o,
  output logic [IW-1:0] run_idx_o,
  output logic          access_o,
  output logic          ack_o,
  output logic          load_o
);
  logic we_q, re_q, run_q, acc_q, ack_q;
  logic [IW-1:0] idx_q;
  logic take;

  // a pending read blocks new hits for one cycle
  assign take = hit_i && !re_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q  <= 1'b0;
      re_q  <= 1'b0;
      run_q <= 1'b0;
      acc_q <= 1'b0;
      ack_q <= 1'b0;
      idx_q <= '0;
    end else begin
      we_q  <= take && op_i == OP_WRITE;
      re_q  <= take && op_i == OP_READ;
      run_q <= take && op_i == OP_RUN;
      acc_q <= take && op_i == OP_NORM;
      ack_q <= (take && op_i == OP_WRITE) || re_q;
      if (take) idx_q <= idx_i;
    end
  end

  assign ram_we_o  = we_q;
  assign ram_re_o  = re_q;
  assign ram_idx_o = idx_q;
  assign run_req_o = run_q;
  assign run_idx_o = idx_q;
  assign access_o  = acc_q;
  assign ack_o     = ack_q;
  assign load_o    = re_q;

  // R4
  wr_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> ack_o);
  // R4
  hit_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && op_i == OP_WRITE && !ram_re_o) |=> ram_we_o && ram_idx_o == $past(idx_i));
  // R5
  rd_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_re_o |=> ack_o);
  // R9
  rd_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_re_o |=> !ram_re_o);
  // R6
  run_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_req_o |-> !ack_o && !ram_we_o && !ram_re_o);
  // R3
  strobe_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ram_we_o, ram_re_o, run_req_o, access_o}));
endmodule

// File: rtl/pram_cmd_if.sv
module pram_cmd_if
  import pram_cmd_pkg::*;
#(
  parameter int DW = 32,
  parameter int DEPTH = 64,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  input  logic              bank_hit_i,
  output logic              bank_ack_o,
  output logic              mem_access_o,
  output logic              ram_we_o,
  output logic              ram_re_o,
  output logic [IW-1:0]     ram_idx_o,
  output logic [DW-1:0]     ram_wdata_o,
  input  logic [DW-1:0]     ram_rdata_i,
  output logic              run_req_o,
  output logic [IW-1:0]     run_idx_o,
  output logic [DW-1:0]     run_addr_o
);
  pram_op_e      op;
  logic [IW-1:0] idx;
  logic          load;

  pram_cmd_regs #(.DW(DW), .IW(IW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (reg_wr_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .load_i      (load),
    .load_data_i (ram_rdata_i),
    .rdata_o     (reg_rdata_o),
    .data_o      (ram_wdata_o),
    .xaddr_o     (run_addr_o),
    .op_o        (op),
    .idx_o       (idx)
  );

  pram_cmd_exec #(.IW(IW)) u_exec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hit_i     (bank_hit_i),
    .op_i      (op),
    .idx_i     (idx),
    .ram_we_o  (ram_we_o),
    .ram_re_o  (ram_re_o),
    .ram_idx_o (ram_idx_o),
    .run_req_o (run_req_o),
    .run_idx_o (run_idx_o),
    .access_o  (mem_access_o),
    .ack_o     (bank_ack_o),
    .load_o    (load)
  );
endmodule

// File: tb/pram_cmd_if_test.sv
module pram_cmd_if_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        hit = 1'b0;
  logic        ack, acc, we, re, run;
  logic [5:0]  ridx, runidx;
  logic [31:0] wdata, rdata, runaddr;

  logic [31:0] mem [64];
  logic [31:0] expm [64];
  int errors = 0, checks = 0, we_cnt = 0, re_cnt = 0, cyc = 0;

  pram_cmd_if uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .bank_hit_i(hit),
    .bank_ack_o(ack), .mem_access_o(acc), .ram_we_o(we), .ram_re_o(re),
    .ram_idx_o(ridx), .ram_wdata_o(wdata), .ram_rdata_i(rdata),
    .run_req_o(run), .run_idx_o(runidx), .run_addr_o(runaddr));

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rdata = mem[ridx];
  always @(posedge clk) if (we) mem[ridx] <= wdata;
  always @(negedge clk) begin
    if (we) we_cnt++;
    if (re) re_cnt++;
  end

  function automatic logic [31:0] mode_word(logic [1:0] op, logic [5:0] idx);
    logic [31:0] w = '0;
    w[9:8] = op;
    w[5:0] = idx;
    return w;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rreg(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  logic c1_we, c1_re, c1_run, c1_acc, c1_ack, c2_ack;
  logic [5:0] c1_idx, c1_runidx;
  logic [31:0] c1_wd, c1_runaddr;

  // one-cycle bank hit; capture the two following cycles
  task automatic bank_hit();
    @(negedge clk);
    hit = 1'b1;
    @(posedge clk);
    #1;
    c1_we = we; c1_re = re; c1_run = run; c1_acc = acc; c1_ack = ack;
    c1_idx = ridx; c1_wd = wdata; c1_runidx = runidx; c1_runaddr = runaddr;
    @(negedge clk);
    hit = 1'b0;
    @(posedge clk);
    #1 c2_ack = ack;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 50000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] v, mw;
    logic [5:0] ids [20];
    int s;
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 64; i++) begin mem[i] = '0; expm[i] = '0; end
    #1;
    // R1 reset state
    chk("R1 strobes", {27'd0, we, re, run, acc, ack}, 32'd0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    rreg(2'd0, v); chk("R1 data", v, 0);
    rreg(2'd1, v); chk("R1 addr", v, 0);
    rreg(2'd2, v); chk("R1 mode", v, 0);

    // R2 readback and field layout
    wreg(2'd0, 32'hdeadbeef); rreg(2'd0, v); chk("R2 data", v, 32'hdeadbeef);
    wreg(2'd1, 32'h1234abcd); rreg(2'd1, v); chk("R2 addr", v, 32'h1234abcd);
    wreg(2'd2, 32'hffff_ffff); rreg(2'd2, v); chk("R2 mode", v, mode_word(2'b11, 6'h3f));
    wreg(2'd3, 32'h5555_5555); rreg(2'd3, v); chk("R2 ofs3", v, 0);

    // R3 normal access
    wreg(2'd2, mode_word(2'b00, 6'd9));
    bank_hit();
    chk("R3 access", {28'd0, c1_acc, c1_we, c1_re, c1_run}, 32'h8);
    chk("R3 noack", {31'd0, c1_ack | c2_ack}, 0);

    // R8 arming alone does nothing
    s = we_cnt;
    wreg(2'd0, 32'h0bad_f00d);
    wreg(2'd2, mode_word(2'b01, 6'd5));
    repeat (3) @(negedge clk);
    chk("R8 no write", we_cnt, s);
    chk("R8 mem untouched", mem[5], 0);

    // R4 directed write at top index
    wreg(2'd2, mode_word(2'b01, 6'd63));
    bank_hit();
    chk("R4 we", {31'd0, c1_we}, 1);
    chk("R4 ack", {31'd0, c1_ack}, 1);
    chk("R4 idx", c1_idx, 63);
    chk("R4 wdata", c1_wd, 32'h0bad_f00d);
    expm[63] = 32'h0bad_f00d;

    // R7 opcode persists: repeated hits write again
    s = we_cnt;
    wreg(2'd0, 32'h7777_0001);
    bank_hit();
    bank_hit();
    chk("R7 two writes", we_cnt, s + 2);
    rreg(2'd2, v); chk("R7 mode kept", v, mode_word(2'b01, 6'd63));
    expm[63] = 32'h7777_0001;

    // R4 random writes
    for (int i = 0; i < 20; i++) begin
      logic [31:0] w = $urandom;
      ids[i] = 6'($urandom % 63);
      wreg(2'd0, w);
      wreg(2'd2, mode_word(2'b01, ids[i]));
      bank_hit();
      chk("R4 rand idx", c1_idx, ids[i]);
      chk("R4 rand data", c1_wd, w);
      expm[ids[i]] = w;
    end

    // R5 read back every stored index
    for (int i = 0; i < 20; i++) begin
      wreg(2'd2, mode_word(2'b10, ids[i]));
      bank_hit();
      chk("R5 re", {31'd0, c1_re}, 1);
      chk("R5 idx", c1_idx, ids[i]);
      chk("R5 ack late", {30'd0, c1_ack, c2_ack}, 1);
      rreg(2'd0, v); chk("R5 data", v, expm[ids[i]]);
    end
    wreg(2'd2, mode_word(2'b10, 6'd63));
    bank_hit();
    rreg(2'd0, v); chk("R5 top", v, expm[63]);

    // R9 back-to-back hits under read
    s = re_cnt;
    wreg(2'd2, mode_word(2'b10, 6'd0));
    @(negedge clk); hit = 1'b1;
    @(negedge clk); @(negedge clk); hit = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 single read", re_cnt, s + 1);

    // R6 run
    wreg(2'd1, 32'hcafe_0042);
    mw = mode_word(2'b11, 6'd3);
    wreg(2'd2, mw);
    s = we_cnt;
    bank_hit();
    chk("R6 run", {28'd0, c1_run, c1_we, c1_re, c1_acc}, 32'h8);
    chk("R6 idx", c1_runidx, 3);
    chk("R6 addr", c1_runaddr, 32'hcafe_0042);
    chk("R6 noack", {31'd0, c1_ack | c2_ack}, 0);
    chk("R6 nowrite", we_cnt, s);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule